// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller turns single-word requests from a small CPU core into bus cycles on an external 64 KB memory space. Eight shared pins carry the low address byte first and the data byte afterwards. A dedicated port carries the high address byte. An active-high latch strobe tells an external transparent latch when the shared pins hold the low address. Three active-low enables select the target of the data phase: program-store enable for code reads, and a read strobe and a write strobe for data.

Every cycle runs through four phases, each with its own parameterised length. In the address phase the latch strobe is high. In the hold phase the strobe is low but the address is still driven. In the data phase one enable is low. In the release phase all strobes are inactive. The core raises `req_valid` with the address, kind and write data, and keeps them there until `done` pulses. For reads the result is then valid on `rdata`.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0 and `done`=0.
- R2: A request is accepted only in idle. After acceptance `ale` is high for exactly ADDR_CLKS cycles, with `ad_oe`=1 and `ad_out` equal to `req_addr[7:0]`.
- R3: `ale` falls while the low address is still driven, and it stays low with the address driven and all enables inactive for HOLD_CLKS cycles before any enable goes low.
- R4: `req_kind` encoding: 2'b00 selects a code read on `psen_n`, 2'b10 a data write on `wr_n`, and 2'b01 or 2'b11 a data read on `rd_n`. The selected enable is low for exactly DATA_CLKS cycles.
- R5: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time, and all three are high when idle.
- R6: During a write, `ad_oe`=1 and `ad_out` equals the write data on every cycle in which `wr_n` is low.
- R7: During a read the shared port is released (`ad_oe`=0) while the enable is low. `rdata` takes the `ad_in` value of the last clock before the enable rises.
- R8: `hi_addr` equals `req_addr[15:8]` from the first address cycle to the end of the cycle. A change of `req_addr` after acceptance does not affect `hi_addr` or the address that is latched.
- R9: `done` is high for exactly one clock, on the last release cycle. That cycle is the (ADDR_CLKS+HOLD_CLKS+DATA_CLKS+REL_CLKS)-th cycle after acceptance, and all enables and `ale` are inactive in the cycle that follows.
- R10: Asserting `rst` in the middle of a bus cycle returns all strobes to their idle levels on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_kind | input | 2 | 00 code read, 01/11 data read, 10 data write |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Data returned by the last read |
| ad_out | output | 8 | Shared port output value (low address, then data) |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port value seen from the pins |
| hi_addr | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code memory output enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The assertions take for granted that `rst` is driven synchronously and that every phase length parameter is at least one. They make no assumption about how `req_addr` or `req_wdata` behave once a cycle is under way. The stimulus drives requests only at the falling clock edge and drops `req_valid` in the cycle where `done` is seen. In the middle of each cycle it deliberately scrambles `req_addr`, so the captured address is exercised without any promise from the core that the address stays stable.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_DATA = 3'd3,
    PH_REL  = 3'd4
  } phase_e;

  // 2'b10 writes; 2'b00 reads code; anything else reads data
  function automatic logic kind_is_write(input logic [1:0] k);
    return k == 2'b10;
  endfunction

  function automatic logic kind_is_code(input logic [1:0] k);
    return k == 2'b00;
  endfunction

  function automatic int phase_len(input phase_e ph, input int a, input int h,
                                   input int d, input int r);
    case (ph)
      PH_ADDR: return a;
      PH_HOLD: return h;
      PH_DATA: return d;
      PH_REL:  return r;
      default: return 1;
    endcase
  endfunction

  function automatic phase_e phase_next(input phase_e ph);
    case (ph)
      PH_ADDR: return PH_HOLD;
      PH_HOLD: return PH_DATA;
      PH_DATA: return PH_REL;
      default: return PH_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_CLKS = 2,
  parameter int HOLD_CLKS = 1,
  parameter int DATA_CLKS = 3,
  parameter int REL_CLKS  = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_e phase,
  output logic   last,
  output logic   done
);
  localparam int MAX_LEN = (ADDR_CLKS > DATA_CLKS ? ADDR_CLKS : DATA_CLKS)
                         + HOLD_CLKS + REL_CLKS;
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;
  int               cur_len;

  always_comb begin
    cur_len = phase_len(phase, ADDR_CLKS, HOLD_CLKS, DATA_CLKS, REL_CLKS);
    last    = (phase != PH_IDLE) && (int'(cnt) == cur_len - 1);
    done    = last && (phase == PH_REL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      cnt <= '0;
      if (start) phase <= PH_ADDR;
    end else if (last) begin
      phase <= phase_next(phase);
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: after done the sequencer is idle and cannot start in the same cycle
  p_done_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> (phase == PH_IDLE));
  // R9: done lasts one clock
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  phase_e     phase,
  input  logic       last,
  input  logic [1:0] req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic [7:0] ad_in,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  output logic [7:0] hi_addr,
  output logic       ale,
  output logic       psen_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic [7:0] rdata
);
  logic [15:0] addr_q;
  logic [7:0]  wdata_q;
  logic [1:0]  kind_q;
  logic        in_addr, in_data, is_wr, is_code, sample_rd;

  always_comb begin
    is_wr     = kind_is_write(kind_q);
    is_code   = kind_is_code(kind_q);
    in_addr   = (phase == PH_ADDR) || (phase == PH_HOLD);
    in_data   = (phase == PH_DATA);
    sample_rd = in_data && last && !is_wr;
    ale       = (phase == PH_ADDR);
    ad_oe     = in_addr || (in_data && is_wr);
    ad_out    = in_addr ? addr_q[7:0] : wdata_q;
    hi_addr   = addr_q[15:8];
    psen_n    = !(in_data && is_code);
    rd_n      = !(in_data && !is_code && !is_wr);
    wr_n      = !(in_data && is_wr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      kind_q  <= 2'b01;
      rdata   <= '0;
    end else begin
      if (start && phase == PH_IDLE) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        kind_q  <= req_kind;
      end
      if (sample_rd) rdata <= ad_in;
    end
  end

  // R5: at most one enable low
  p_one_enable_r5: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  // R5: all enables high while idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (psen_n && rd_n && wr_n && !ale));
  // R6: write data driven while the write strobe is low
  p_wr_driven_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);
  // R7: port released while a read enable is low
  p_rd_released_r7: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !psen_n) |-> !ad_oe);
  // R3: latch strobe falls with the address still on the port
  p_ale_fall_addr_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (ad_oe && $stable(ad_out)));
  // R8: high address stable through a cycle
  p_hi_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(hi_addr));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_CLKS = 2,
  parameter int HOLD_CLKS = 1,
  parameter int DATA_CLKS = 3,
  parameter int REL_CLKS  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        done,
  output logic [7:0]  rdata,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  hi_addr,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n
);
  phase_e phase;
  logic   last;
  logic   start;

  // a request is taken only from idle
  assign start = req_valid && (phase == PH_IDLE);

  xbus_seq #(
    .ADDR_CLKS(ADDR_CLKS), .HOLD_CLKS(HOLD_CLKS),
    .DATA_CLKS(DATA_CLKS), .REL_CLKS(REL_CLKS)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .phase(phase), .last(last), .done(done)
  );

  xbus_pins u_pins (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .last(last),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata)
  );

  // R10: reset clears any cycle on the next edge
  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (ale == 1'b0 && psen_n && rd_n && wr_n && !ad_oe && !done));
endmodule

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
  localparam int A = 2, H = 1, D = 3, R = 1;
  localparam int TOTAL = A + H + D + R;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic done, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0] rdata, ad_out, hi_addr, ad_in;

  int n_chk = 0, n_fail = 0;
  logic [7:0] lat = 0;
  logic [7:0] dmem [0:255];
  logic [7:0] ref_mem [0:255];

  always #2.5 clk = ~clk;

  xbus_ctrl #(.ADDR_CLKS(A), .HOLD_CLKS(H), .DATA_CLKS(D), .REL_CLKS(R)) u_xbus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n));

  function automatic logic [7:0] code_val(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction
  function automatic logic [7:0] slot(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  // external memory model: code ROM and data RAM behind the latch
  always_comb begin
    if (!psen_n)    ad_in = code_val({hi_addr, lat});
    else if (!rd_n) ad_in = dmem[slot({hi_addr, lat})];
    else            ad_in = 8'hFF;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [1:0] kind, input logic [15:0] addr, input logic [7:0] wd);
    int cyc = 0, n_ale = 0, n_hold = 0, n_en = 0, n_other = 0, n_done = 0;
    logic [7:0] wcap = 8'h00;
    logic ale_ok = 1, hi_ok = 1, wr_ok = 1, rd_ok = 1;
    logic is_w = (kind == 2'b10), is_c = (kind == 2'b00);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_addr = addr; req_wdata = wd;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) req_addr = ~addr;  // must be ignored mid-cycle
      if (hi_addr !== addr[15:8]) hi_ok = 0;
      if (ale) begin
        n_ale++; lat = ad_out;
        if (!ad_oe || ad_out !== addr[7:0]) ale_ok = 0;
      end
      if (!ale && ad_oe && psen_n && rd_n && wr_n) n_hold++;
      if (is_c ? !psen_n : is_w ? !wr_n : !rd_n) n_en++;
      if (is_c ? (!rd_n || !wr_n) : is_w ? (!rd_n || !psen_n) : (!psen_n || !wr_n)) n_other++;
      if (!wr_n) begin
        if (!ad_oe || ad_out !== wd) wr_ok = 0;
        wcap = ad_out;
        dmem[slot({hi_addr, lat})] = ad_out;
      end
      if ((!rd_n || !psen_n) && ad_oe) rd_ok = 0;
      if (done) begin n_done++; break; end
    end
    req_valid = 0;
    if (cyc >= 200) check("watchdog", 0, 1);
    check("R2 ale cycles", n_ale, A);
    check("R2 low address on port", ale_ok, 1);
    check("R3 hold cycles", n_hold, H);
    check("R4 enable cycles", n_en, D);
    check("R5 other enables idle", n_other, 0);
    check("R8 high address held", hi_ok, 1);
    check("R8 latched low address", lat, addr[7:0]);
    check("R9 done latency", cyc, TOTAL);
    if (is_w) begin
      ref_mem[slot(addr)] = wd;
      check("R6 write data driven", wr_ok, 1);
      check("R6 write captured", wcap, wd);
    end else begin
      check("R7 port released", rd_ok, 1);
      check("R7 read data", rdata, is_c ? code_val(addr) : ref_mem[slot(addr)]);
    end
    @(negedge clk);
    check("R9 done single pulse", done, 0);
    check("R9 quiet after done", {ale, psen_n, rd_n, wr_n}, 4'b0111);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    for (int i = 0; i < 256; i++) begin dmem[i] = 8'(i * 7); ref_mem[i] = 8'(i * 7); end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {ale, psen_n, rd_n, wr_n, ad_oe, done}, 6'b011100);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {ale, psen_n, rd_n, wr_n, ad_oe, done}, 6'b011100);
    // directed corners
    txn(2'b10, 16'hFFFF, 8'h00);
    txn(2'b01, 16'hFFFF, 8'h00);
    txn(2'b00, 16'h0000, 8'h00);
    txn(2'b11, 16'h1234, 8'h00);
    txn(2'b10, 16'h00FF, 8'hFF);
    txn(2'b01, 16'h00FF, 8'h00);
    // reset in the middle of a cycle
    @(negedge clk);
    req_valid = 1; req_kind = 2'b10; req_addr = 16'hABCD; req_wdata = 8'h3C;
    repeat (A + H + 1) @(negedge clk);
    check("R10 strobe active before reset", wr_n, 0);
    rst = 1; req_valid = 0;
    @(negedge clk);
    check("R10 idle after mid-cycle reset", {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    rst = 0;
    // random traffic
    for (int i = 0; i < 60; i++) begin
      logic [1:0] k = 2'($urandom_range(0, 3));
      logic [15:0] ad = 16'($urandom);
      logic [7:0] w = 8'($urandom);
      txn(k, ad, w);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule